// File: doc/BRIEF.md
# Three-Phase Gate Drive Sequencer

This block is the digital control core of a three-phase half-bridge gate driver. Each phase receives a low-side command and an active-low high-side command. It produces two gate enables, one for the low-side switch and one for the high-side switch. In normal operation the low-side command has priority on its phase. A turn-on delay counted in clock cycles keeps the two switches of a phase from conducting together. Turn-off is never delayed.

Three conditions act on all phases at once: a disable input, an undervoltage flag and a start-up sequence. After reset, and again whenever the undervoltage flag clears, the core spends one cycle with every gate off. It then holds all low-side gates on and all high-side gates off for a programmable number of cycles, so that the bootstrap capacitors can charge. A bypass input removes the delay timers and the interlock, so that both switches of a phase can be on at once, as switched-reluctance drives need. The dead-time and refresh lengths are cycle counts captured while reset is held.

Top module: `gate_drive_core`

## Requirements
- R1: The high-side command is active-low. With the low-side command at 0, a high-side command of 0 turns the high-side gate on and a 1 turns it off in the same cycle.
- R2: Outside bypass, a low-side command of 1 turns that phase's high-side gate off in the same cycle, whatever the high-side command is.
- R3: Outside bypass, a low-side gate turns on D cycles after its enable condition becomes true, where D is the captured dead time. A high-side gate turns on after D+HI_SKEW cycles, with HI_SKEW defaulting to 1. Either gate turns off in the same cycle its enable condition drops.
- R4: If a gate's enable condition drops before its delay expires, the delay count restarts from zero.
- R5: Outside bypass, the low-side and high-side gates of one phase are never on together.
- R6: With bypass at 1 and no forcing condition, the low-side gate equals the low-side command and the high-side gate equals the inverted high-side command in the same cycle, with both allowed on.
- R7: A disable input of 1 drives all six gates to 0 in the same cycle. This overrides bypass, refresh and every command. After disable is released, each gate waits its full turn-on delay again.
- R8: An undervoltage flag of 1 drives all six gates to 0 in the same cycle and re-arms the start-up sequence, which runs again once the flag returns to 0.
- R9: Once released from reset, or once undervoltage clears, the core holds all gates off for one cycle. It then holds every low-side gate on and every high-side gate off for exactly N cycles, where N is the captured refresh length, before normal operation begins. N = 0 skips the refresh.
- R10: The dead-time and refresh lengths are captured while reset is held. Later changes on those inputs have no effect until the next reset.
- R11: All gates are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset, also captures configuration |
| deadCycles | input | CNT_W | Turn-on delay in cycles, captured in reset |
| refreshCycles | input | CNT_W | Start-up refresh length in cycles, captured in reset |
| bypassEn | input | 1 | 1 removes turn-on delays and interlock |
| disableIn | input | 1 | 1 forces all gates off |
| underVolt | input | 1 | 1 forces all gates off and re-arms refresh |
| loCmd | input | NUM_PH | Low-side commands, active-high, one bit per phase |
| hiCmdN | input | NUM_PH | High-side commands, active-low, one bit per phase |
| loGate | output | NUM_PH | Low-side gate enables |
| hiGate | output | NUM_PH | High-side gate enables |

## Verification
The bench samples the cycle just before each turn-on and the cycle of each turn-on. A design with an off-by-one counter, or one that left out the extra high-side cycle, would switch one cycle early or late. It cuts a command short in the middle of the delay and releases disable while commands are held. A timer that kept its partial count would then turn the gate on too soon. It lets undervoltage clear with a high-side command pending, which catches a design that fails to re-arm the refresh or that lets the high side through during it. It also changes the configuration inputs after reset, runs a zero-length refresh and drives both switches of a phase on in bypass, where a design that kept its interlock would hold the high side off.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_REFRESH = 2'd1,
    ST_RUN     = 2'd2
  } seqState_t;

  typedef struct packed {
    logic gateOff;
    logic refreshOn;
    logic bypass;
  } ctrlStrobes_t;
endpackage

// File: rtl/gdc_control.sv
module gdc_control
  import gdc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] refreshCycles,
  input  logic             bypassEn,
  input  logic             disableIn,
  input  logic             underVolt,
  output ctrlStrobes_t     strobes
);
  seqState_t        state;
  logic [CNT_W-1:0] refreshCfg;
  logic [CNT_W-1:0] refreshLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ARMED;
      refreshCfg  <= refreshCycles;
      refreshLeft <= '0;
    end else if (underVolt) begin
      state <= ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (refreshCfg == '0) begin
            state <= ST_RUN;
          end else begin
            state       <= ST_REFRESH;
            refreshLeft <= refreshCfg - 1'b1;
          end
        end
        ST_REFRESH: begin
          if (refreshLeft == '0) state <= ST_RUN;
          else refreshLeft <= refreshLeft - 1'b1;
        end
        ST_RUN:  state <= ST_RUN;
        default: state <= ST_ARMED;
      endcase
    end
  end

  always_comb begin
    strobes.gateOff   = disableIn | underVolt | (state == ST_ARMED);
    strobes.refreshOn = (state == ST_REFRESH);
    strobes.bypass    = bypassEn;
  end

  // R8
  uv_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> state == ST_ARMED);

  // R9
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFRESH) && !underVolt && (refreshLeft != '0) |=> state == ST_REFRESH);

  // R9
  armed_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED) |=> state != ST_RUN || $past(refreshCfg) == '0);
endmodule

// File: rtl/gdc_phase.sv
module gdc_phase
  import gdc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int HI_SKEW = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] deadCfg,
  input  ctrlStrobes_t     strobes,
  input  logic             loCmd,
  input  logic             hiCmdN,
  output logic             loGate,
  output logic             hiGate
);
  localparam int TW = CNT_W + 1;

  logic [TW-1:0] loTarget, hiTarget;
  logic [TW-1:0] loTimer, hiTimer;
  logic          loEn, hiEn;
  logic          loNormal, hiNormal;

  assign loTarget = {1'b0, deadCfg};
  assign hiTarget = {1'b0, deadCfg} + TW'(HI_SKEW);

  always_comb begin
    loEn = loCmd & ~strobes.gateOff & ~strobes.bypass;
    hiEn = ~hiCmdN & ~loCmd & ~strobes.gateOff & ~strobes.refreshOn & ~strobes.bypass;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !loEn) loTimer <= '0;
    else if (loTimer < loTarget) loTimer <= loTimer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !hiEn) hiTimer <= '0;
    else if (hiTimer < hiTarget) hiTimer <= hiTimer + 1'b1;
  end

  always_comb begin
    loNormal = loEn & (loTimer >= loTarget);
    hiNormal = hiEn & (hiTimer >= hiTarget);
    loGate   = ~strobes.gateOff &
               (strobes.refreshOn | (strobes.bypass ? loCmd : loNormal));
    hiGate   = ~strobes.gateOff & ~strobes.refreshOn &
               (strobes.bypass ? ~hiCmdN : hiNormal);
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bypass |-> !(loGate && hiGate));

  // R3
  hi_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HI_SKEW > 0) && !strobes.bypass && $rose(hiGate) |-> $past(hiEn));

  // R2
  lo_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bypass && loCmd |-> !hiGate);
endmodule

// File: rtl/gdc_datapath.sv
module gdc_datapath
  import gdc_pkg::*;
#(
  parameter int NUM_PH  = 3,
  parameter int CNT_W   = 8,
  parameter int HI_SKEW = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  deadCycles,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_PH-1:0] loCmd,
  input  logic [NUM_PH-1:0] hiCmdN,
  output logic [NUM_PH-1:0] loGate,
  output logic [NUM_PH-1:0] hiGate
);
  logic [CNT_W-1:0] deadCfg;

  always_ff @(posedge clk) begin
    if (!rstN) deadCfg <= deadCycles;
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    gdc_phase #(
      .CNT_W  (CNT_W),
      .HI_SKEW(HI_SKEW)
    ) u_phase (
      .clk    (clk),
      .rstN   (rstN),
      .deadCfg(deadCfg),
      .strobes(strobes),
      .loCmd  (loCmd[p]),
      .hiCmdN (hiCmdN[p]),
      .loGate (loGate[p]),
      .hiGate (hiGate[p])
    );
  end

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(deadCfg));
endmodule

// File: rtl/gate_drive_core.sv
module gate_drive_core
  import gdc_pkg::*;
#(
  parameter int NUM_PH  = 3,
  parameter int CNT_W   = 8,
  parameter int HI_SKEW = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  deadCycles,
  input  logic [CNT_W-1:0]  refreshCycles,
  input  logic              bypassEn,
  input  logic              disableIn,
  input  logic              underVolt,
  input  logic [NUM_PH-1:0] loCmd,
  input  logic [NUM_PH-1:0] hiCmdN,
  output logic [NUM_PH-1:0] loGate,
  output logic [NUM_PH-1:0] hiGate
);
  ctrlStrobes_t strobes;

  gdc_control #(.CNT_W(CNT_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .refreshCycles(refreshCycles),
    .bypassEn     (bypassEn),
    .disableIn    (disableIn),
    .underVolt    (underVolt),
    .strobes      (strobes)
  );

  gdc_datapath #(
    .NUM_PH (NUM_PH),
    .CNT_W  (CNT_W),
    .HI_SKEW(HI_SKEW)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .deadCycles(deadCycles),
    .strobes   (strobes),
    .loCmd     (loCmd),
    .hiCmdN    (hiCmdN),
    .loGate    (loGate),
    .hiGate    (hiGate)
  );

  // R7
  disable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    disableIn |-> (loGate == '0) && (hiGate == '0));

  // R8
  uv_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |-> (loGate == '0) && (hiGate == '0));
endmodule

// File: tb/gate_drive_core_test.sv
`timescale 1ns/1ps
module gate_drive_core_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] deadCycles = 8'd4;
  logic [7:0] refreshCycles = 8'd6;
  logic       bypassEn = 1'b0;
  logic       disableIn = 1'b0;
  logic       underVolt = 1'b0;
  logic [2:0] loCmd = 3'b000;
  logic [2:0] hiCmdN = 3'b111;
  logic [2:0] loGate, hiGate;

  int checkCount = 0;
  int passCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gate_drive_core uut (
    .clk(clk), .rstN(rstN), .deadCycles(deadCycles), .refreshCycles(refreshCycles),
    .bypassEn(bypassEn), .disableIn(disableIn), .underVolt(underVolt),
    .loCmd(loCmd), .hiCmdN(hiCmdN), .loGate(loGate), .hiGate(hiGate)
  );

  task automatic chk(input string req, input logic [2:0] expLo, input logic [2:0] expHi);
    checkCount++;
    if (loGate === expLo && hiGate === expHi) passCount++;
    else $display("FAIL %s: lo=%b hi=%b expected lo=%b hi=%b at %0t",
                  req, loGate, hiGate, expLo, expHi, $time);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset(input logic [7:0] dead, input logic [7:0] refr);
    step(1);
    rstN = 1'b0; deadCycles = dead; refreshCycles = refr;
    bypassEn = 0; disableIn = 0; underVolt = 0; loCmd = 3'b000; hiCmdN = 3'b111;
    step(3);
    loCmd = 3'b111; hiCmdN = 3'b000; #0.5;
    chk("R11 outputs off in reset", 3'b000, 3'b000);
    loCmd = 3'b000; hiCmdN = 3'b111;
    rstN = 1'b1; #0.5;
    chk("R9 armed cycle off", 3'b000, 3'b000);
  endtask

  task automatic testRefresh();
    step(1); chk("R9 refresh first cycle", 3'b111, 3'b000);
    step(5); chk("R9 refresh last cycle", 3'b111, 3'b000);
    step(1); chk("R9 refresh ended", 3'b000, 3'b000);
  endtask

  task automatic testLoDelay();
    loCmd = 3'b001; #0.5; chk("R3 lo not immediate", 3'b000, 3'b000);
    step(3); chk("R3 lo one cycle early", 3'b000, 3'b000);
    step(1); chk("R3 lo on after D", 3'b001, 3'b000);
    loCmd = 3'b000; #0.5; chk("R3 lo off immediately", 3'b000, 3'b000);
    step(1);
  endtask

  task automatic testHiDelay();
    hiCmdN = 3'b110; #0.5; chk("R1 hi not immediate", 3'b000, 3'b000);
    step(4); chk("R3 hi one cycle early", 3'b000, 3'b000);
    step(1); chk("R1 hi on after D+1", 3'b000, 3'b001);
    hiCmdN = 3'b111; #0.5; chk("R1 hi cmd high turns off", 3'b000, 3'b000);
    step(1);
  endtask

  task automatic testOverride();
    hiCmdN = 3'b110; step(5); chk("R1 hi on", 3'b000, 3'b001);
    loCmd = 3'b001; #0.5; chk("R2 lo cmd kills hi", 3'b000, 3'b000);
    step(4); chk("R5 lo on after dead gap", 3'b001, 3'b000);
    loCmd = 3'b000; #0.5; chk("R5 both off at handover", 3'b000, 3'b000);
    step(4); chk("R3 hi waits after lo", 3'b000, 3'b000);
    step(1); chk("R3 hi on after handover", 3'b000, 3'b001);
    hiCmdN = 3'b111; step(1);
  endtask

  task automatic testRestart();
    loCmd = 3'b010; step(2);
    loCmd = 3'b000; step(1);
    loCmd = 3'b010; #0.5;
    step(3); chk("R4 restarted count early", 3'b000, 3'b000);
    step(1); chk("R4 restarted count done", 3'b010, 3'b000);
    loCmd = 3'b000; step(1);
  endtask

  task automatic testMixed();
    loCmd = 3'b001; hiCmdN = 3'b101; #0.5;
    step(4); chk("R3 mixed lo on hi pending", 3'b001, 3'b000);
    step(1); chk("R1 mixed phases", 3'b001, 3'b010);
    loCmd = 3'b000; hiCmdN = 3'b111; step(1);
  endtask

  task automatic testDisable();
    loCmd = 3'b111; step(4); chk("R3 all lo on", 3'b111, 3'b000);
    disableIn = 1'b1; #0.5; chk("R7 disable forces off", 3'b000, 3'b000);
    bypassEn = 1'b1; hiCmdN = 3'b000; #0.5; chk("R7 disable beats bypass", 3'b000, 3'b000);
    step(2); bypassEn = 1'b0; hiCmdN = 3'b111; #0.5;
    disableIn = 1'b0; #0.5; chk("R7 release waits", 3'b000, 3'b000);
    step(3); chk("R7 still waiting", 3'b000, 3'b000);
    step(1); chk("R7 delay after release", 3'b111, 3'b000);
  endtask

  task automatic testUv();
    underVolt = 1'b1; #0.5; chk("R8 uv forces off", 3'b000, 3'b000);
    step(2);
    loCmd = 3'b000; hiCmdN = 3'b000;
    underVolt = 1'b0; #0.5; chk("R8 armed after uv", 3'b000, 3'b000);
    step(1); chk("R8 refresh re-armed", 3'b111, 3'b000);
    step(5); chk("R9 refresh holds hi off", 3'b111, 3'b000);
    step(1); chk("R9 run starts", 3'b000, 3'b000);
    step(4); chk("R3 hi early after refresh", 3'b000, 3'b000);
    step(1); chk("R1 hi on after refresh", 3'b000, 3'b111);
    hiCmdN = 3'b111; step(1);
  endtask

  task automatic testBypass();
    bypassEn = 1'b1; loCmd = 3'b101; hiCmdN = 3'b001; #0.5;
    chk("R6 bypass follows", 3'b101, 3'b110);
    hiCmdN = 3'b111; #0.5; chk("R6 bypass hi follows", 3'b101, 3'b000);
    bypassEn = 1'b0; loCmd = 3'b000; step(1);
  endtask

  task automatic testCfgHold();
    deadCycles = 8'd1; refreshCycles = 8'd0;
    loCmd = 3'b100; #0.5;
    step(3); chk("R10 dead unchanged early", 3'b000, 3'b000);
    step(1); chk("R10 dead unchanged on", 3'b100, 3'b000);
    loCmd = 3'b000; step(1);
  endtask

  task automatic testZero();
    doReset(8'd0, 8'd0);
    loCmd = 3'b001;
    step(1); chk("R9 zero refresh skipped", 3'b001, 3'b000);
    loCmd = 3'b000; hiCmdN = 3'b011; #0.5; chk("R3 hi skew", 3'b000, 3'b000);
    step(1); chk("R3 hi after skew only", 3'b000, 3'b100);
  endtask

  initial begin
    doReset(8'd4, 8'd6);
    testRefresh();
    testLoDelay();
    testHiDelay();
    testOverride();
    testRestart();
    testMixed();
    testDisable();
    testUv();
    testBypass();
    testCfgHold();
    testZero();
    finished = 1'b1;
    $display("%0d/%0d checks passed", passCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=done");
      $display("%0d/%0d checks passed", passCount, checkCount);
      $finish;
    end
  end
endmodule